// File: doc/BRIEF.md
# Forward Quad Kill Queue

This block is a queue of 2x2 fragment quads placed between the early depth/stencil test and the fragment thread spawner. Every quad carries a quad position inside a 16x16 pixel tile, a four-bit coverage mask, an opaque flag and a tag that travels with it. The upstream test has already decided the quad is in front. If that quad is opaque, it removes its covered samples from older quads at the same position that are still waiting. A quad whose coverage becomes empty never reaches the shader.

At the output, the quad at the head is expanded into four per-fragment thread beats over four accepted cycles. Lanes whose coverage bit is clear are still emitted, marked inactive, so the lane order never changes. Both edges are valid/ready streams:
- A quad is taken on a cycle where `s_valid` and `s_ready` are both high. `s_ready` drops in the same cycle that `full` rises.
- A thread beat moves on a cycle where `t_valid` and `t_ready` are both high. While `t_ready` is low, the offered beat is held unchanged.

Top module: `fqk_queue`

## Requirements
- R1: An input quad is accepted exactly on a cycle with `s_valid` and `s_ready` both high. `s_ready` is the inverse of `full`, and a quad offered while `full` is high is lost to nothing: it is neither stored nor issued.
- R2: `full` rises when `DEPTH` quads are waiting in the queue. The quad held in the output expander is not counted. With `t_ready` low from an empty start, `DEPTH`+1 quads are accepted and then `full`=1.
- R3: An accepted quad with `s_opaque`=1 clears the bits of its mask from every older waiting quad with the same `s_pos`. Other bits of those quads are unchanged.
- R4: An accepted quad with `s_opaque`=0 modifies no other quad.
- R5: An opaque quad leaves waiting quads at a different position unchanged.
- R6: A quad whose mask is zero at the head is removed without producing any thread beat. This covers a mask cleared by a kill and a mask accepted as zero.
- R7: Each surviving quad produces four beats with `t_lane` = 0, 1, 2, 3 in that order. `t_active` equals mask bit `t_lane` (bit 0 top-left, bit 1 top-right, bit 2 bottom-left, bit 3 bottom-right). `t_pos` and `t_tag` are those of the quad.
- R8: While `t_valid`=1 and `t_ready`=0, the beat on `t_pos`, `t_tag`, `t_lane` and `t_active` stays unchanged in the next cycle.
- R9: A quad that leaves the queue for the expander in the same cycle as an opaque kill aimed at it issues with its mask from before the kill.
- R10: Surviving quads are issued in the order they were accepted.
- R11: After reset the queue is empty, `t_valid`=0, `full`=0 and `s_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| s_valid | input | 1 | Input quad offered |
| s_ready | output | 1 | Queue can take a quad |
| s_pos | input | POS_W | Quad position within the tile |
| s_mask | input | 4 | Coverage mask of the quad |
| s_opaque | input | 1 | Quad hides what lies behind it |
| s_tag | input | TAG_W | Payload carried to the threads |
| t_valid | output | 1 | Thread beat offered |
| t_ready | input | 1 | Spawner takes the beat |
| t_pos | output | POS_W | Position of the issuing quad |
| t_tag | output | TAG_W | Tag of the issuing quad |
| t_lane | output | 2 | Fragment index inside the quad |
| t_active | output | 1 | Coverage bit of this lane |
| full | output | 1 | All queue slots occupied |

## Verification
Several properties are checked on every cycle:
- Input is refused while the queue is full.
- A thread beat holds still while back-pressured.
- Lanes step 0 to 3 and a new quad starts at lane 0.

Which coverage bits survive, which quads are skipped, arrival order and the result of a kill racing a dequeue depend on the mix of positions, masks and opacity. Only the bench shows these: it sweeps every pair of victim and killer masks and compares each issued beat with a reference model.

// File: rtl/fqk_pkg.sv
package fqk_pkg;
  localparam int LANES = 4;
  typedef logic [1:0]       lane_t;
  typedef logic [LANES-1:0] cov_t;
endpackage

// File: rtl/fqk_ptrs.sv
module fqk_ptrs #(
  parameter int DEPTH = 128,
  parameter int PTR_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] wr_idx,
  output logic [PTR_W-1:0] rd_idx,
  output logic             full
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign wr_idx = wr_q;
  assign rd_idx = rd_q;
  assign full   = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/fqk_store.sv
module fqk_store import fqk_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int PTR_W = 7,
  parameter int POS_W = 6,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PTR_W-1:0] wr_idx,
  input  logic [POS_W-1:0] wr_pos,
  input  cov_t             wr_mask,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic             kill_en,
  input  logic [POS_W-1:0] kill_pos,
  input  cov_t             kill_mask,
  input  logic             pop,
  input  logic [PTR_W-1:0] rd_idx,
  output logic             hd_vld,
  output logic [POS_W-1:0] hd_pos,
  output cov_t             hd_mask,
  output logic [TAG_W-1:0] hd_tag
);
  logic             vld_a  [DEPTH];
  logic [POS_W-1:0] pos_a  [DEPTH];
  cov_t             mask_a [DEPTH];
  logic [TAG_W-1:0] tag_a  [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic             v_q;
    logic [POS_W-1:0] p_q;
    cov_t             m_q;
    logic [TAG_W-1:0] g_q;
    logic             hit_w, hit_r, hit_k;

    assign hit_w = wr_en && (wr_idx == PTR_W'(i));
    assign hit_r = pop && (rd_idx == PTR_W'(i));
    assign hit_k = kill_en && v_q && (p_q == kill_pos);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        p_q <= '0;
        m_q <= '0;
        g_q <= '0;
      end else if (hit_w) begin
        v_q <= 1'b1;
        p_q <= wr_pos;
        m_q <= wr_mask;
        g_q <= wr_tag;
      end else if (hit_r) begin
        v_q <= 1'b0;
      end else if (hit_k) begin
        m_q <= m_q & ~kill_mask;
      end
    end

    assign vld_a[i]  = v_q;
    assign pos_a[i]  = p_q;
    assign mask_a[i] = m_q;
    assign tag_a[i]  = g_q;
  end

  assign hd_vld  = vld_a[rd_idx];
  assign hd_pos  = pos_a[rd_idx];
  assign hd_mask = mask_a[rd_idx];
  assign hd_tag  = tag_a[rd_idx];
endmodule

// File: rtl/fqk_expand.sv
module fqk_expand import fqk_pkg::*; #(
  parameter int POS_W = 6,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [POS_W-1:0] ld_pos,
  input  cov_t             ld_mask,
  input  logic [TAG_W-1:0] ld_tag,
  output logic             can_load,
  output logic             t_valid,
  input  logic             t_ready,
  output logic [POS_W-1:0] t_pos,
  output logic [TAG_W-1:0] t_tag,
  output lane_t            t_lane,
  output logic             t_active
);
  localparam lane_t LAST = lane_t'(LANES - 1);

  logic             busy_q;
  lane_t            lane_q;
  logic [POS_W-1:0] pos_q;
  cov_t             mask_q;
  logic [TAG_W-1:0] tag_q;

  assign can_load = !busy_q || (lane_q == LAST && t_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lane_q <= '0;
      pos_q  <= '0;
      mask_q <= '0;
      tag_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      lane_q <= '0;
      pos_q  <= ld_pos;
      mask_q <= ld_mask;
      tag_q  <= ld_tag;
    end else if (busy_q && t_ready) begin
      if (lane_q == LAST) busy_q <= 1'b0;
      else                lane_q <= lane_q + 1'b1;
    end
  end

  assign t_valid  = busy_q;
  assign t_pos    = pos_q;
  assign t_tag    = tag_q;
  assign t_lane   = lane_q;
  assign t_active = mask_q[lane_q];
endmodule

// File: rtl/fqk_queue.sv
module fqk_queue import fqk_pkg::*; #(
  parameter int DEPTH = 128,
  parameter int POS_W = 6,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [POS_W-1:0] s_pos,
  input  logic [3:0]       s_mask,
  input  logic             s_opaque,
  input  logic [TAG_W-1:0] s_tag,
  output logic             t_valid,
  input  logic             t_ready,
  output logic [POS_W-1:0] t_pos,
  output logic [TAG_W-1:0] t_tag,
  output logic [1:0]       t_lane,
  output logic             t_active,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             push, pop, load, can_load;
  logic [PTR_W-1:0] wr_idx, rd_idx;
  logic             hd_vld;
  logic [POS_W-1:0] hd_pos;
  cov_t             hd_mask;
  logic [TAG_W-1:0] hd_tag;
  logic             hd_live, hd_dead;

  assign s_ready = !full;
  assign push    = s_valid && s_ready;
  assign hd_live = hd_vld && (hd_mask != '0);
  assign hd_dead = hd_vld && (hd_mask == '0);
  assign load    = hd_live && can_load;
  assign pop     = load || hd_dead;

  fqk_ptrs #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push),
    .pop    (pop),
    .wr_idx (wr_idx),
    .rd_idx (rd_idx),
    .full   (full)
  );

  fqk_store #(.DEPTH(DEPTH), .PTR_W(PTR_W), .POS_W(POS_W), .TAG_W(TAG_W)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (push),
    .wr_idx    (wr_idx),
    .wr_pos    (s_pos),
    .wr_mask   (s_mask),
    .wr_tag    (s_tag),
    .kill_en   (push && s_opaque),
    .kill_pos  (s_pos),
    .kill_mask (s_mask),
    .pop       (pop),
    .rd_idx    (rd_idx),
    .hd_vld    (hd_vld),
    .hd_pos    (hd_pos),
    .hd_mask   (hd_mask),
    .hd_tag    (hd_tag)
  );

  fqk_expand #(.POS_W(POS_W), .TAG_W(TAG_W)) u_exp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .ld_pos   (hd_pos),
    .ld_mask  (hd_mask),
    .ld_tag   (hd_tag),
    .can_load (can_load),
    .t_valid  (t_valid),
    .t_ready  (t_ready),
    .t_pos    (t_pos),
    .t_tag    (t_tag),
    .t_lane   (t_lane),
    .t_active (t_active)
  );
endmodule

// File: rtl/fqk_queue_chk.sv
module fqk_queue_chk #(
  parameter int POS_W = 6,
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             full,
  input logic             t_valid,
  input logic             t_ready,
  input logic [POS_W-1:0] t_pos,
  input logic [TAG_W-1:0] t_tag,
  input logic [1:0]       t_lane,
  input logic             t_active
);
  // R1, R2: a full queue refuses input
  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !s_ready);

  // R8: a refused beat is held
  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && !t_ready) |=> (t_valid && $stable(t_pos) && $stable(t_tag)
                               && $stable(t_lane) && $stable(t_active)));

  // R7: lanes advance by one inside a quad
  a_r7_lane_step: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && t_ready && t_lane != 2'd3) |=> (t_valid && t_lane == $past(t_lane) + 2'd1));

  // R7: after the last lane either idle or a new quad at lane 0
  a_r7_lane_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (t_valid && t_ready && t_lane == 2'd3) |=> (!t_valid || t_lane == 2'd0));

  // R7: a quad always starts at lane 0
  a_r7_start_lane: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(t_valid) |-> (t_lane == 2'd0));
endmodule

bind fqk_queue fqk_queue_chk #(.POS_W(POS_W), .TAG_W(TAG_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .full     (full),
  .t_valid  (t_valid),
  .t_ready  (t_ready),
  .t_pos    (t_pos),
  .t_tag    (t_tag),
  .t_lane   (t_lane),
  .t_active (t_active)
);

// File: tb/sim_fqk_queue.sv
`timescale 1ns/1ps
module sim_fqk_queue;
  localparam int DEPTH = 8;
  localparam int POS_W = 6;
  localparam int TAG_W = 8;
  localparam int MAXQ  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_opaque = 1'b0, t_ready = 1'b0;
  logic [POS_W-1:0] s_pos = '0;
  logic [3:0] s_mask = '0;
  logic [TAG_W-1:0] s_tag = '0;
  logic s_ready, t_valid, t_active, full;
  logic [POS_W-1:0] t_pos;
  logic [TAG_W-1:0] t_tag;
  logic [1:0] t_lane;

  int errors = 0;
  int checks = 0;
  int nq = 0;
  logic [POS_W-1:0] qp [MAXQ];
  logic [3:0]       qm [MAXQ];
  logic             qo [MAXQ];
  logic [TAG_W-1:0] qt [MAXQ];
  logic [TAG_W-1:0] tag_seq = 8'h10;

  always #5 clk = ~clk;

  fqk_queue #(.DEPTH(DEPTH), .POS_W(POS_W), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_pos(s_pos), .s_mask(s_mask),
    .s_opaque(s_opaque), .s_tag(s_tag),
    .t_valid(t_valid), .t_ready(t_ready), .t_pos(t_pos), .t_tag(t_tag),
    .t_lane(t_lane), .t_active(t_active), .full(full)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic add_q(input logic [POS_W-1:0] p, input logic [3:0] m, input logic o);
    qp[nq] = p; qm[nq] = m; qo[nq] = o; qt[nq] = tag_seq;
    tag_seq = tag_seq + 8'd1;
    nq++;
  endtask

  task automatic push_all();
    for (int i = 0; i < nq; i++) begin
      @(negedge clk);
      s_valid = 1'b1; s_pos = qp[i]; s_mask = qm[i]; s_opaque = qo[i]; s_tag = qt[i];
      while (!s_ready) @(negedge clk);
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // Quad 0 enters an idle block and leaves the queue at once, so it is never a victim.
  task automatic drain(input int mode, input string req);
    logic [3:0] em [MAXQ];
    logic [POS_W-1:0] bp [4*MAXQ];
    logic [TAG_W-1:0] bt [4*MAXQ];
    logic [1:0] bl [4*MAXQ];
    logic ba [4*MAXQ];
    int nb = 0, got = 0, idle = 0;
    logic hold = 1'b0;
    logic [POS_W-1:0] hp; logic [TAG_W-1:0] ht; logic [1:0] hl; logic ha;
    logic [7:0] lf = 8'hA5;
    for (int j = 0; j < nq; j++) em[j] = qm[j];
    for (int j = 1; j < nq; j++)
      for (int k = j + 1; k < nq; k++)
        if (qo[k] && qp[k] == qp[j]) em[j] = em[j] & ~qm[k];
    for (int j = 0; j < nq; j++)
      if (em[j] != 4'd0)
        for (int l = 0; l < 4; l++) begin
          bp[nb] = qp[j]; bt[nb] = qt[j]; bl[nb] = 2'(l); ba[nb] = em[j][l]; nb++;
        end
    for (int cyc = 0; cyc < nb * 8 + 60 && idle < 8; cyc++) begin
      t_ready = (mode == 0) ? 1'b1 : (lf[0] | lf[3]);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      if (hold) begin
        chk(t_valid && t_pos == hp && t_tag == ht && t_lane == hl && t_active == ha,
            "R8", "held beat tag", int'(t_tag), int'(ht));
        hold = 1'b0;
      end
      if (t_valid && t_ready) begin
        if (got < nb) begin
          chk(t_pos == bp[got] && t_tag == bt[got], req, "beat tag/pos R10",
              int'({t_tag, 2'b00, t_pos}), int'({bt[got], 2'b00, bp[got]}));
          chk(t_lane == bl[got] && t_active == ba[got], req, "lane/active R7",
              int'({t_lane, t_active}), int'({bl[got], ba[got]}));
        end else begin
          chk(1'b0, req, "extra beat tag", int'(t_tag), 0);
        end
        got++;
      end else if (t_valid) begin
        hold = 1'b1; hp = t_pos; ht = t_tag; hl = t_lane; ha = t_active;
      end
      if (got >= nb && !t_valid) idle++;
      @(negedge clk);
    end
    chk(got == nb, req, "beat count R6", got, nb);
    t_ready = 1'b0;
    nq = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!t_valid && s_ready && !full, "R11", "reset state", int'({t_valid, s_ready, full}), 3'b010);

    // R10 R7: plain pass-through, distinct positions
    add_q(6'd1, 4'hF, 1'b0); add_q(6'd2, 4'h5, 1'b1); add_q(6'd3, 4'hA, 1'b0); add_q(6'd4, 4'h9, 1'b1);
    push_all(); drain(0, "R10");

    // R3: opaque partial kill
    add_q(6'd63, 4'hF, 1'b0); add_q(6'd5, 4'hF, 1'b0); add_q(6'd5, 4'h3, 1'b1);
    push_all(); drain(0, "R3");

    // R4: translucent same position does not kill
    add_q(6'd63, 4'hF, 1'b0); add_q(6'd5, 4'hF, 1'b0); add_q(6'd5, 4'hF, 1'b0);
    push_all(); drain(0, "R4");

    // R5: opaque elsewhere does not kill
    add_q(6'd63, 4'hF, 1'b0); add_q(6'd5, 4'hF, 1'b0); add_q(6'd6, 4'hF, 1'b1);
    push_all(); drain(0, "R5");

    // R6: killed-empty and accepted-empty quads are skipped
    add_q(6'd63, 4'hF, 1'b0); add_q(6'd5, 4'h6, 1'b0); add_q(6'd5, 4'hF, 1'b1);
    add_q(6'd7, 4'h0, 1'b0); add_q(6'd8, 4'h4, 1'b0);
    push_all(); drain(0, "R6");

    // R9: kill racing the dequeue of its victim
    add_q(6'd9, 4'hF, 1'b0); add_q(6'd9, 4'hF, 1'b1);
    push_all(); drain(0, "R9");

    // R8: back-pressure with an irregular ready pattern
    add_q(6'd63, 4'hF, 1'b0); add_q(6'd5, 4'hE, 1'b0); add_q(6'd11, 4'h7, 1'b0);
    add_q(6'd5, 4'h2, 1'b1); add_q(6'd11, 4'h1, 1'b1); add_q(6'd12, 4'hB, 1'b0);
    push_all(); drain(1, "R8");

    // R3 R6: every victim mask against every opaque killer mask
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        add_q(6'd63, 4'h8, 1'b0); add_q(6'd20, 4'(a), 1'b0); add_q(6'd20, 4'(b), 1'b1);
        push_all(); drain(0, "R3");
      end

    // R1 R2: fill until full, refused quad never appears
    for (int i = 0; i <= DEPTH; i++) add_q(6'(30 + i), 4'hC, 1'b0);
    nq = DEPTH;
    push_all();
    chk(!full && s_ready, "R2", "not full one short", int'(full), 0);
    nq = DEPTH + 1;
    @(negedge clk);
    s_valid = 1'b1; s_pos = qp[DEPTH]; s_mask = qm[DEPTH]; s_opaque = 1'b0; s_tag = qt[DEPTH];
    @(posedge clk);
    @(negedge clk);
    s_tag = 8'hEE; s_pos = 6'd40;
    chk(full && !s_ready, "R2", "full after depth+1", int'({full, s_ready}), 2'b10);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!s_ready, "R1", "ready while full", int'(s_ready), 0);
    end
    s_valid = 1'b0;
    drain(0, "R1");

    summary();
  end
endmodule